// File: doc/BRIEF.md
# Frame Transmit Sequencer for a Dword Serial Link

This block is the transmit half of a host link layer. It sends one frame of 32-bit payload dwords over a dword-wide PHY stream. Flow control and termination travel in-band as primitive dwords. When nothing is pending it fills the line with the idle primitive. When a frame is requested, it announces the frame and waits for the far end to grant it. It then sends a start marker and streams the payload from a first-word-fall-through FIFO. Whenever the far end asks it to pause, it answers with a pause acknowledge. After the payload it sends an end marker and then a wait-for-termination primitive until the receiver reports good or bad status.

The received dword input is assumed to be already cleaned of repeat codes. CRC and scrambling are applied upstream of the payload FIFO. The primitive values are parameters; their defaults are the usual 8b/10b-era encodings with a K28.3 or K28.5 control byte in the lowest byte. Completion is reported by a one-cycle `done` pulse and a held `err` level.

Top module: `link_frame_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `tx_dword` is the idle primitive (default 32'hB5B5957C), with `done` and `err` low after reset.
- R2: `tx_isk` is 4'b0001 on every cycle that carries a primitive and 4'b0000 on every cycle that carries a payload dword.
- R3: An accepted request makes the block send the frame-ready primitive (default 32'h5757B57C) on every cycle until a grant (default 32'h4A4A957C) is seen on `rx_dword`, the granting cycle included.
- R4: The cycle after the grant, exactly one start primitive (default 32'h3737B57C) is sent.
- R5: In the data phase the payload dwords leave in FIFO order, one per cycle. `pay_pop` is high exactly in the cycles that send a payload dword, and `frm_len` dwords are sent in total.
- R6: In the data phase, a cycle whose `rx_dword` is the pause request (default 32'hD5D5AA7C) sends the pause acknowledge (default 32'h9595AA7C) and leaves the FIFO untouched.
- R7: The cycle after the last payload dword, exactly one end primitive (default 32'hD5D5B57C) is sent, followed by the wait primitive (default 32'h5858B57C).
- R8: The wait primitive repeats until `rx_dword` carries good status (default 32'h3535B57C) or bad status (default 32'h5656B57C), the deciding cycle included. The next cycle sends idle.
- R9: `done` is high for exactly one cycle, the cycle after the status primitive was received.
- R10: `err` goes high with `done` when the status was bad and low when it was good. It keeps that level until the next request is accepted, which clears it.
- R11: A request with `frm_len` of zero sends the start primitive followed directly by the end primitive, and pops nothing.
- R12: `frm_req` and `frm_len` are ignored while a frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_req | input | 1 | Frame request, accepted only while idle |
| frm_len | input | LEN_W | Payload length in dwords, sampled on acceptance |
| pay_dword | input | 32 | Head of the payload FIFO (first-word-fall-through) |
| pay_pop | output | 1 | Pops the FIFO head at the clock edge |
| rx_dword | input | 32 | Received dword from the far end, repeat codes removed |
| tx_dword | output | 32 | Dword sent to the PHY |
| tx_isk | output | 4 | Per-byte control-character flag for `tx_dword` |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Level: last frame ended with bad status |

## Verification
`tx_dword`, `tx_isk` and `pay_pop` are due in the same cycle as the received dword that decides them. Each state change therefore shows one cycle after the grant, the pause request or the status primitive that caused it. `done` and `err` are registered and appear one cycle after the status was received. The bench drives every input half a period before the edge and compares all five outputs against its behavioural model just after that, once per cycle. It advances the model with the same inputs the edge will take, so every expectation lines up with the cycle in which the output is due.

// File: rtl/ftx_pkg.sv
package ftx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RDY,
        ST_SOF,
        ST_DATA,
        ST_EOF,
        ST_WTRM
    } ftx_state_e;

    typedef enum logic [2:0] {
        SEL_SYNC,
        SEL_XRDY,
        SEL_SOF,
        SEL_PAY,
        SEL_HOLDA,
        SEL_EOF,
        SEL_WTRM
    } ftx_sel_e;

    // Flags decoded from the received dword
    typedef struct packed {
        logic grant;
        logic pause;
        logic good;
        logic bad;
    } ftx_rx_t;

    localparam logic [31:0] DEF_SYNC  = 32'hB5B5957C;
    localparam logic [31:0] DEF_XRDY  = 32'h5757B57C;
    localparam logic [31:0] DEF_RRDY  = 32'h4A4A957C;
    localparam logic [31:0] DEF_SOF   = 32'h3737B57C;
    localparam logic [31:0] DEF_EOF   = 32'hD5D5B57C;
    localparam logic [31:0] DEF_HOLD  = 32'hD5D5AA7C;
    localparam logic [31:0] DEF_HOLDA = 32'h9595AA7C;
    localparam logic [31:0] DEF_WTRM  = 32'h5858B57C;
    localparam logic [31:0] DEF_ROK   = 32'h3535B57C;
    localparam logic [31:0] DEF_RERR  = 32'h5656B57C;

    localparam logic [3:0] ISK_PRIM = 4'b0001;
    localparam logic [3:0] ISK_DATA = 4'b0000;

    // Output selection for a state; the data phase depends on the pause flag
    function automatic ftx_sel_e sel_of(input ftx_state_e st, input logic pause);
        case (st)
            ST_RDY:  sel_of = SEL_XRDY;
            ST_SOF:  sel_of = SEL_SOF;
            ST_DATA: sel_of = pause ? SEL_HOLDA : SEL_PAY;
            ST_EOF:  sel_of = SEL_EOF;
            ST_WTRM: sel_of = SEL_WTRM;
            default: sel_of = SEL_SYNC;
        endcase
    endfunction

endpackage

// File: rtl/ftx_rx_decode.sv
module ftx_rx_decode
    import ftx_pkg::*;
#(
    parameter logic [31:0] P_RRDY = DEF_RRDY,
    parameter logic [31:0] P_HOLD = DEF_HOLD,
    parameter logic [31:0] P_ROK  = DEF_ROK,
    parameter logic [31:0] P_RERR = DEF_RERR
) (
    input  logic [31:0] rx_dword,
    output ftx_rx_t     flags
);
    always_comb begin
        flags.grant = (rx_dword == P_RRDY);
        flags.pause = (rx_dword == P_HOLD);
        flags.good  = (rx_dword == P_ROK);
        flags.bad   = (rx_dword == P_RERR);
    end
endmodule

// File: rtl/ftx_fsm.sv
module ftx_fsm
    import ftx_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frm_req,
    input  logic [LEN_W-1:0] frm_len,
    input  ftx_rx_t          flags,
    output ftx_sel_e         sel,
    output logic             pay_pop,
    output logic             done,
    output logic             err
);
    ftx_state_e       state_q, state_d;
    logic [LEN_W-1:0] len_q, cnt_q, cnt_nx;
    logic             accept, finish, last_beat;

    assign sel       = sel_of(state_q, flags.pause);
    assign pay_pop   = (state_q == ST_DATA) && !flags.pause;
    assign cnt_nx    = cnt_q + 1'b1;
    assign last_beat = pay_pop && (cnt_nx == len_q);
    assign accept    = (state_q == ST_IDLE) && frm_req;
    assign finish    = (state_q == ST_WTRM) && (flags.good || flags.bad);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (frm_req)     state_d = ST_RDY;
            ST_RDY:  if (flags.grant) state_d = ST_SOF;
            ST_SOF:  state_d = (len_q == '0) ? ST_EOF : ST_DATA;
            ST_DATA: if (last_beat)   state_d = ST_EOF;
            ST_EOF:  state_d = ST_WTRM;
            ST_WTRM: if (finish)      state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            len_q   <= '0;
            cnt_q   <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= finish;
            if (accept) begin
                len_q <= frm_len;
                cnt_q <= '0;
                err   <= 1'b0;
            end else if (pay_pop) begin
                cnt_q <= cnt_nx;
            end
            if (finish) err <= flags.bad;
        end
    end
endmodule

// File: rtl/ftx_word_mux.sv
module ftx_word_mux
    import ftx_pkg::*;
#(
    parameter logic [31:0] P_SYNC  = DEF_SYNC,
    parameter logic [31:0] P_XRDY  = DEF_XRDY,
    parameter logic [31:0] P_SOF   = DEF_SOF,
    parameter logic [31:0] P_EOF   = DEF_EOF,
    parameter logic [31:0] P_HOLDA = DEF_HOLDA,
    parameter logic [31:0] P_WTRM  = DEF_WTRM
) (
    input  ftx_sel_e    sel,
    input  logic [31:0] pay_dword,
    output logic [31:0] tx_dword,
    output logic [3:0]  tx_isk
);
    always_comb begin
        tx_isk = ISK_PRIM;
        case (sel)
            SEL_XRDY:  tx_dword = P_XRDY;
            SEL_SOF:   tx_dword = P_SOF;
            SEL_HOLDA: tx_dword = P_HOLDA;
            SEL_EOF:   tx_dword = P_EOF;
            SEL_WTRM:  tx_dword = P_WTRM;
            SEL_PAY: begin
                tx_dword = pay_dword;
                tx_isk   = ISK_DATA;
            end
            default:   tx_dword = P_SYNC;
        endcase
    end
endmodule

// File: rtl/link_frame_tx.sv
module link_frame_tx
    import ftx_pkg::*;
#(
    parameter int          LEN_W   = 8,
    parameter logic [31:0] P_SYNC  = DEF_SYNC,
    parameter logic [31:0] P_XRDY  = DEF_XRDY,
    parameter logic [31:0] P_RRDY  = DEF_RRDY,
    parameter logic [31:0] P_SOF   = DEF_SOF,
    parameter logic [31:0] P_EOF   = DEF_EOF,
    parameter logic [31:0] P_HOLD  = DEF_HOLD,
    parameter logic [31:0] P_HOLDA = DEF_HOLDA,
    parameter logic [31:0] P_WTRM  = DEF_WTRM,
    parameter logic [31:0] P_ROK   = DEF_ROK,
    parameter logic [31:0] P_RERR  = DEF_RERR
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frm_req,
    input  logic [LEN_W-1:0] frm_len,
    input  logic [31:0]      pay_dword,
    output logic             pay_pop,
    input  logic [31:0]      rx_dword,
    output logic [31:0]      tx_dword,
    output logic [3:0]       tx_isk,
    output logic             done,
    output logic             err
);
    ftx_rx_t  flags;
    ftx_sel_e sel;

    ftx_rx_decode #(
        .P_RRDY(P_RRDY), .P_HOLD(P_HOLD), .P_ROK(P_ROK), .P_RERR(P_RERR)
    ) u_dec (
        .rx_dword(rx_dword),
        .flags   (flags)
    );

    ftx_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .frm_req(frm_req),
        .frm_len(frm_len),
        .flags  (flags),
        .sel    (sel),
        .pay_pop(pay_pop),
        .done   (done),
        .err    (err)
    );

    ftx_word_mux #(
        .P_SYNC(P_SYNC), .P_XRDY(P_XRDY), .P_SOF(P_SOF),
        .P_EOF(P_EOF), .P_HOLDA(P_HOLDA), .P_WTRM(P_WTRM)
    ) u_mux (
        .sel      (sel),
        .pay_dword(pay_dword),
        .tx_dword (tx_dword),
        .tx_isk   (tx_isk)
    );
endmodule

// File: rtl/link_frame_tx_chk.sv
module link_frame_tx_chk #(
    parameter int          LEN_W  = 8,
    parameter logic [31:0] P_SYNC = 32'hB5B5957C,
    parameter logic [31:0] P_SOF  = 32'h3737B57C,
    parameter logic [31:0] P_HOLD = 32'hD5D5AA7C,
    parameter logic [31:0] P_WTRM = 32'h5858B57C,
    parameter logic [31:0] P_ROK  = 32'h3535B57C,
    parameter logic [31:0] P_RERR = 32'h5656B57C
) (
    input logic             clk,
    input logic             rst,
    input logic             frm_req,
    input logic [LEN_W-1:0] frm_len,
    input logic [31:0]      pay_dword,
    input logic             pay_pop,
    input logic [31:0]      rx_dword,
    input logic [31:0]      tx_dword,
    input logic [3:0]       tx_isk,
    input logic             done,
    input logic             err
);
    a_r2_isk_payload: assert property (@(posedge clk) disable iff (rst)
        pay_pop |-> (tx_isk == 4'b0000 && tx_dword == pay_dword));

    a_r2_isk_primitive: assert property (@(posedge clk) disable iff (rst)
        !pay_pop |-> (tx_isk == 4'b0001));

    a_r6_no_pop_on_pause: assert property (@(posedge clk) disable iff (rst)
        pay_pop |-> (rx_dword != P_HOLD));

    a_r4_single_sof: assert property (@(posedge clk) disable iff (rst)
        (tx_dword == P_SOF && tx_isk == 4'b0001) |=> (tx_dword != P_SOF));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_done_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(tx_dword) == P_WTRM &&
                         ($past(rx_dword) == P_ROK || $past(rx_dword) == P_RERR)));

    a_r10_err_level: assert property (@(posedge clk) disable iff (rst)
        done |-> (err == ($past(rx_dword) == P_RERR)));

    a_r8_sync_after: assert property (@(posedge clk) disable iff (rst)
        done |-> (tx_dword == P_SYNC));
endmodule

bind link_frame_tx link_frame_tx_chk #(
    .LEN_W(LEN_W), .P_SYNC(P_SYNC), .P_SOF(P_SOF), .P_HOLD(P_HOLD),
    .P_WTRM(P_WTRM), .P_ROK(P_ROK), .P_RERR(P_RERR)
) u_chk (.*);

// File: tb/tb_link_frame_tx.sv
module tb_link_frame_tx;
    localparam int LEN_W = 8;
    localparam logic [31:0] SYNC  = 32'hB5B5957C, XRDY = 32'h5757B57C,
                            RRDY  = 32'h4A4A957C, SOFP = 32'h3737B57C,
                            EOFP  = 32'hD5D5B57C, HOLD = 32'hD5D5AA7C,
                            HOLDA = 32'h9595AA7C, WTRM = 32'h5858B57C,
                            ROK   = 32'h3535B57C, RERR = 32'h5656B57C;
    // model states
    localparam int M_IDLE = 0, M_RDY = 1, M_SOF = 2, M_DATA = 3, M_EOF = 4, M_WTRM = 5;

    logic clk = 1'b0, rst = 1'b1;
    logic frm_req = 1'b0;
    logic [LEN_W-1:0] frm_len = '0;
    logic [31:0] pay_dword = '0, rx_dword = SYNC;
    logic pay_pop, done, err;
    logic [31:0] tx_dword;
    logic [3:0] tx_isk;

    always #5 clk = ~clk;

    link_frame_tx #(.LEN_W(LEN_W)) dut (
        .clk(clk), .rst(rst), .frm_req(frm_req), .frm_len(frm_len),
        .pay_dword(pay_dword), .pay_pop(pay_pop), .rx_dword(rx_dword),
        .tx_dword(tx_dword), .tx_isk(tx_isk), .done(done), .err(err)
    );

    int n_chk = 0, n_fail = 0, ncyc = 0;
    bit wd_hit = 0;

    // model and responder state
    logic [31:0] pay_q[$];
    int mst = M_IDLE, mlen = 0, mcnt = 0, wcnt = 0, dcnt = 0;
    bit mdone = 0, merr = 0;
    bit start_pend = 0, noise = 0, use_err = 0;
    int req_len = 0, rdy_dly = 0, wt_dly = 0;
    logic [31:0] hmask = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, ncyc, act, exp);
        end
    endtask

    function automatic string tag_of(input int st);
        case (st)
            M_IDLE: return "R1";
            M_RDY:  return "R3";
            M_SOF:  return "R4";
            M_DATA: return "R5";
            M_EOF:  return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic cycle();
        logic [31:0] etx;
        bit eprim, epop, fin;
        @(negedge clk);
        ncyc++;
        if (ncyc > 100000) begin
            if (!wd_hit) chk(0, "watchdog", ncyc, 0);
            wd_hit = 1;
            return;
        end
        // far-end responder
        rx_dword = SYNC;
        case (mst)
            M_RDY:  if (wcnt >= rdy_dly) rx_dword = RRDY;
            M_DATA: if (dcnt < 32 && hmask[dcnt]) rx_dword = HOLD;
            M_WTRM: if (wcnt >= wt_dly) rx_dword = use_err ? RERR : ROK;
            default: ;
        endcase
        frm_req = (mst == M_IDLE && start_pend) || (noise && mst != M_IDLE && mst != M_WTRM);
        frm_len = (mst == M_IDLE) ? LEN_W'(req_len) : LEN_W'(8'hA5);
        pay_dword = (pay_q.size() > 0) ? pay_q[0] : 32'hDEAD0000;
        #1;
        // expected outputs
        eprim = 1; epop = 0;
        case (mst)
            M_RDY:  etx = XRDY;
            M_SOF:  etx = SOFP;
            M_DATA: if (rx_dword == HOLD) etx = HOLDA;
                    else begin etx = pay_dword; eprim = 0; epop = 1; end
            M_EOF:  etx = EOFP;
            M_WTRM: etx = WTRM;
            default: etx = SYNC;
        endcase
        chk(tx_dword == etx, (mst == M_DATA && rx_dword == HOLD) ? "R6" :
            (mlen == 0 && mst == M_EOF) ? "R11" : tag_of(mst), tx_dword, etx);
        chk(tx_isk == (eprim ? 4'b0001 : 4'b0000), "R2", 32'(tx_isk), eprim ? 1 : 0);
        chk(pay_pop == epop, (mst == M_DATA) ? "R6" : "R5", 32'(pay_pop), 32'(epop));
        chk(done == mdone, "R9", 32'(done), 32'(mdone));
        chk(err == merr, "R10", 32'(err), 32'(merr));
        if (noise && mst != M_IDLE && frm_req) chk(tx_dword == etx, "R12", tx_dword, etx);
        // advance model
        fin = 0;
        case (mst)
            M_IDLE: if (frm_req) begin
                mlen = int'(frm_len); mcnt = 0; merr = 0; start_pend = 0;
                mst = M_RDY; wcnt = 0;
            end
            M_RDY: begin
                if (rx_dword == RRDY) mst = M_SOF; else wcnt++;
            end
            M_SOF: begin mst = (mlen == 0) ? M_EOF : M_DATA; dcnt = 0; end
            M_DATA: begin
                if (epop) begin
                    void'(pay_q.pop_front());
                    mcnt++;
                    if (mcnt == mlen) mst = M_EOF;
                end
                dcnt++;
            end
            M_EOF: begin mst = M_WTRM; wcnt = 0; end
            default: begin
                if (rx_dword == ROK || rx_dword == RERR) begin
                    fin = 1; merr = (rx_dword == RERR); mst = M_IDLE;
                end else wcnt++;
            end
        endcase
        mdone = fin;
    endtask

    task automatic run_frame(input int len, input int rd, input logic [31:0] hm,
                             input int wd, input bit e, input bit nz, input int seed);
        for (int i = 0; i < len; i++) pay_q.push_back(32'h1000_0000 * seed + i * 32'h0101_0101 + 7);
        req_len = len; rdy_dly = rd; hmask = hm; wt_dly = wd; use_err = e; noise = nz;
        start_pend = 1;
        cycle();
        while (!wd_hit && (mst != M_IDLE || start_pend)) cycle();
        noise = 0;
        cycle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        // R1: reset state
        chk(tx_dword == SYNC, "R1", tx_dword, SYNC);
        chk(done == 0 && err == 0, "R1", {done, err}, 0);
        repeat (3) cycle();
        run_frame(4, 0, 32'h0, 0, 0, 0, 1);               // R3 R4 R5 R7 R8
        run_frame(6, 3, 32'h0000_0026, 2, 1, 0, 2);       // R6 pauses, R10 bad status
        repeat (2) cycle();                               // R10 err held
        run_frame(0, 1, 32'h0, 1, 0, 0, 3);               // R11, R10 cleared
        run_frame(5, 2, 32'h0000_0001, 3, 0, 1, 4);       // R12 request noise
        run_frame(1, 0, 32'h0000_000F, 0, 1, 0, 5);       // R6 many pauses, single beat
        run_frame(3, 0, 32'h0, 0, 0, 0, 6);               // back-to-back, R9
        repeat (3) cycle();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule